// File: doc/BRIEF.md
# External Bus Ready Access Stretcher

This block runs read accesses to a slow external region, either a boot ROM area or a peripheral I/O area. A one-cycle start request selects the area. The access then drives that area's active-low chip select and the shared active-low output enable. It holds them for at least the programmed number of wait states. If ready stretching is enabled for the area, the access continues, one extra data cycle at a time, until an external active-low ready input has been seen.

Ready is sampled in one of two ways, chosen by a configuration input. In the synchronous way, ready goes through a single register. In the asynchronous way, it goes through a two-flop synchronizer, which costs one more cycle. The block captures the data bus on the last data cycle and presents it with a one-cycle done strobe. I/O accesses then keep chip select low for one lead-out cycle with output enable released. An optional stall timeout ends an access that never receives ready, and it raises an error flag together with done.

Top module: `bus_ready_stretcher`

## Requirements
- R1: After reset both chip selects and output enable are high (inactive), and done and error are low.
- R2: With ready stretching disabled for the selected area, output enable is low for exactly W+1 consecutive cycles, where W is that area's 4-bit wait-state field. The first of these cycles is the one after the clock edge that samples start.
- R3: With ready stretching enabled, a ready that arrives early never shortens the access below W+1 data cycles.
- R4: In synchronous mode (async select = 0), ready driven low during data cycle j (cycle 0 is the first) makes the last data cycle max(W, j+1).
- R5: In asynchronous mode (async select = 1), ready driven low during data cycle j makes the last data cycle max(W, j+2).
- R6: Each area has its own ready-enable input. When the selected area's enable is 0, the ready input has no effect on the length of the access.
- R7: Area encoding is 0 = ROM, 1 = I/O. A ROM access releases its chip select in the cycle after the last data cycle. An I/O access keeps its chip select low for exactly one further cycle with output enable high, and then releases it.
- R8: Through every data cycle, output enable and the selected area's chip select stay low without a gap, and the two chip selects are never low together.
- R9: Done is high for exactly one cycle, the cycle after the last data cycle. In that cycle the read data output equals the data bus value of the last data cycle.
- R10: A start request while an access is in progress is ignored. It neither changes the running access nor starts another one.
- R11: With ready enabled, a nonzero stall limit T and no ready, the last data cycle is W+T and the error flag is high together with done. When the access ends on ready, the error flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, sampled while idle |
| area_i | input | 1 | Target area: 0 ROM, 1 I/O |
| rom_ws_i | input | WS_W | Minimum wait states for ROM area |
| io_ws_i | input | WS_W | Minimum wait states for I/O area |
| rom_rdy_en_i | input | 1 | Ready stretching enable, ROM area |
| io_rdy_en_i | input | 1 | Ready stretching enable, I/O area |
| async_rdy_i | input | 1 | 1 selects two-flop synchronized ready |
| stall_limit_i | input | TMO_W | Stall cycles before timeout; 0 disables it |
| ext_rdy_n_i | input | 1 | External active-low ready |
| ext_data_i | input | DW | External read data bus |
| rom_cs_n_o | output | 1 | ROM area chip select, active low |
| io_cs_n_o | output | 1 | I/O area chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Timeout error, valid with done |
| rdata_o | output | DW | Captured read data |

## Verification
Several properties are checked on every cycle. The two chip selects are never low together, output enable is never low without a chip select, and done lasts one cycle. Error only appears with done, and the access cannot end while wait states remain. The lead-out is exactly one cycle, and the sampled ready equals the pin value one or two edges earlier, depending on the mode. Only the directed scenarios can show the exact access lengths: the max(W, j+1) and max(W, j+2) rules, the per-area enables and the timeout length. The same holds for the captured data value and for start requests being ignored during an access.

// File: rtl/brs_pkg.sv
package brs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_LEAD = 2'd2
    } brs_state_e;

    localparam logic AREA_ROM = 1'b0;
    localparam logic AREA_IO  = 1'b1;
endpackage

// File: rtl/brs_ready_sampler.sv
module brs_ready_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_i,
    input  logic async_i,
    output logic rdy_o
);
    logic s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = ~rdy_n_i;
        s2_d = s1_q;
        rdy_o = async_i ? s2_q : s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    // R4: single-register path reflects the pin one edge back
    p_sync_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_i && rdy_o) |-> !$past(rdy_n_i));
    // R5: synchronizer path reflects the pin two edges back
    p_async_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (async_i && rdy_o) |-> !$past(rdy_n_i, 2));
endmodule

// File: rtl/brs_stall_timer.sv
module brs_stall_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!stall_i)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
        expired_o = (limit_i != '0) && (cnt_q == limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: the count only grows across consecutive stall cycles
    p_count_needs_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $past(stall_i));
endmodule

// File: rtl/bus_ready_stretcher.sv
module bus_ready_stretcher
    import brs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WS_W  = 4,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             area_i,
    input  logic [WS_W-1:0]  rom_ws_i,
    input  logic [WS_W-1:0]  io_ws_i,
    input  logic             rom_rdy_en_i,
    input  logic             io_rdy_en_i,
    input  logic             async_rdy_i,
    input  logic [TMO_W-1:0] stall_limit_i,
    input  logic             ext_rdy_n_i,
    input  logic [DW-1:0]    ext_data_i,
    output logic             rom_cs_n_o,
    output logic             io_cs_n_o,
    output logic             oe_n_o,
    output logic             done_o,
    output logic             err_o,
    output logic [DW-1:0]    rdata_o
);
    typedef struct packed {
        brs_state_e      state;
        logic            area;
        logic [WS_W-1:0] wcnt;
        logic [DW-1:0]   rdata;
        logic            done;
        logic            err;
    } regs_t;

    regs_t r_d, r_q;

    logic rdy_seen;
    logic tmo_hit;
    logic rdy_used;
    logic at_floor;
    logic stall;
    logic active;

    brs_ready_sampler u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_n_i (ext_rdy_n_i),
        .async_i (async_rdy_i),
        .rdy_o   (rdy_seen)
    );

    brs_stall_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_i   (stall),
        .limit_i   (stall_limit_i),
        .expired_o (tmo_hit)
    );

    always_comb begin
        rdy_used = (r_q.area == AREA_IO) ? io_rdy_en_i : rom_rdy_en_i;
        at_floor = (r_q.wcnt == '0);
        stall    = (r_q.state == ST_DATA) && at_floor && rdy_used && !rdy_seen;

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_DATA;
                    r_d.area  = area_i;
                    r_d.wcnt  = (area_i == AREA_IO) ? io_ws_i : rom_ws_i;
                end
            end
            ST_DATA: begin
                if (!at_floor) begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                end else if (!stall || tmo_hit) begin
                    r_d.rdata = ext_data_i;
                    r_d.done  = 1'b1;
                    r_d.err   = stall;
                    r_d.state = (r_q.area == AREA_IO) ? ST_LEAD : ST_IDLE;
                end
            end
            ST_LEAD: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        active     = (r_q.state != ST_IDLE);
        rom_cs_n_o = !(active && (r_q.area == AREA_ROM));
        io_cs_n_o  = !(active && (r_q.area == AREA_IO));
        oe_n_o     = !(r_q.state == ST_DATA);
        done_o     = r_q.done;
        err_o      = r_q.err;
        rdata_o    = r_q.rdata;
    end

    // R2: an access cannot end while wait states remain
    p_floor_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && r_q.wcnt != '0) |=> !oe_n_o);
    // R8: never both chip selects at once
    p_one_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n_o && !io_cs_n_o));
    // R8: output enable only with a chip select
    p_oe_has_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> !(rom_cs_n_o && io_cs_n_o));
    // R9: done is a single-cycle strobe
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: ROM chip select is already released when done shows
    p_rom_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rom_cs_n_o && oe_n_o));
    // R7: I/O lead-out lasts exactly one cycle
    p_lead_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !io_cs_n_o) |=> (io_cs_n_o && oe_n_o));
    // R11: the error flag never appears without done
    p_err_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
endmodule

// File: tb/bus_ready_stretcher_tb_top.sv
module bus_ready_stretcher_tb_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, area_sel = 1'b0;
    logic [3:0] rom_ws = '0, io_ws = '0;
    logic rom_en = 1'b0, io_en = 1'b0, async_sel = 1'b0;
    logic [7:0] tmo = '0;
    logic rdy_n = 1'b1;
    logic [DW-1:0] ext_data = '0;
    logic rom_cs_n, io_cs_n, oe_n, done, err;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_ready_stretcher #(.DW(DW), .WS_W(4), .TMO_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .area_i(area_sel),
        .rom_ws_i(rom_ws), .io_ws_i(io_ws), .rom_rdy_en_i(rom_en),
        .io_rdy_en_i(io_en), .async_rdy_i(async_sel), .stall_limit_i(tmo),
        .ext_rdy_n_i(rdy_n), .ext_data_i(ext_data),
        .rom_cs_n_o(rom_cs_n), .io_cs_n_o(io_cs_n), .oe_n_o(oe_n),
        .done_o(done), .err_o(err), .rdata_o(rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k, input logic a);
        return 16'hA5C3 ^ DW'(k * 16'h0139) ^ {a, 15'h0};
    endfunction

    // One access: ready driven low from data cycle j (j < 0: never),
    // expected last data cycle exp_last, optional start poke mid-access.
    task automatic run_acc(input string req, input logic a, input int j,
                           input int exp_last, input logic exp_err, input bit poke);
        int  k = 0;
        int  oe_cnt = 0;
        bit  gap = 0;
        bit  got = 0;
        bit  extra = 0;
        @(negedge clk);
        area_sel = a;
        start = 1'b1;
        while (!got && k < 400) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            if (poke && k == 1) begin start = 1'b1; area_sel = !a; end
            if (poke && k == 2) start = 1'b0;
            if (j >= 0 && k >= j) rdy_n = 1'b0;
            if (done) begin
                got = 1;
                chk(k == exp_last + 1, req, k - 1, exp_last);
                chk(oe_cnt == exp_last + 1, req, oe_cnt, exp_last + 1);
                chk(!gap, "R8", gap, 0);
                chk(rdata == pat(exp_last, a), "R9", rdata, pat(exp_last, a));
                chk(err == exp_err, "R11", err, exp_err);
                chk(oe_n && rom_cs_n && (io_cs_n == !a), "R7", {oe_n, rom_cs_n, io_cs_n}, {1'b1, 1'b1, !a});
            end else begin
                if (!oe_n && ((a ? io_cs_n : rom_cs_n) == 1'b0) && ((a ? rom_cs_n : io_cs_n) == 1'b1))
                    oe_cnt++;
                else
                    gap = 1;
                ext_data = pat(k, a);
            end
            k++;
        end
        if (!got) chk(0, req, k, exp_last + 1);
        @(negedge clk);
        rdy_n = 1'b1;
        chk(!done, "R9", done, 0);
        chk(io_cs_n && rom_cs_n, "R7", {rom_cs_n, io_cs_n}, 3);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!oe_n || done) extra = 1;
        end
        if (poke) chk(!extra, "R10", extra, 0);
    endtask

    task automatic t_reset();
        chk(rom_cs_n && io_cs_n && oe_n, "R1", {rom_cs_n, io_cs_n, oe_n}, 7);
        chk(!done && !err, "R1", {done, err}, 0);
    endtask

    task automatic t_no_ready();        // R2
        rom_en = 0; io_en = 0; async_sel = 0; rom_ws = 3;
        run_acc("R2", 1'b0, -1, 3, 1'b0, 0);
    endtask

    task automatic t_ready_ignored();   // R6, ready held low while disabled
        rom_en = 0; io_en = 1; rom_ws = 4;
        run_acc("R6", 1'b0, 0, 4, 1'b0, 0);
        rom_en = 1; io_en = 0; io_ws = 2;
        run_acc("R6", 1'b1, -1, 2, 1'b0, 0);
    endtask

    task automatic t_early_ready();     // R3
        rom_en = 1; async_sel = 0; rom_ws = 2;
        run_acc("R3", 1'b0, 0, 2, 1'b0, 0);
        async_sel = 1; rom_ws = 5;
        run_acc("R3", 1'b0, 0, 5, 1'b0, 0);
    endtask

    task automatic t_sync_stretch();    // R4
        rom_en = 1; async_sel = 0; rom_ws = 1;
        run_acc("R4", 1'b0, 5, 6, 1'b0, 0);
        rom_ws = 0;
        run_acc("R4", 1'b0, 0, 1, 1'b0, 0);
    endtask

    task automatic t_async_stretch();   // R5 on the I/O area, with lead-out (R7)
        io_en = 1; async_sel = 1; io_ws = 1;
        run_acc("R5", 1'b1, 4, 6, 1'b0, 0);
        io_ws = 0;
        run_acc("R5", 1'b1, 0, 2, 1'b0, 0);
    endtask

    task automatic t_timeout();         // R11
        rom_en = 1; async_sel = 0; rom_ws = 2; tmo = 8'd4;
        run_acc("R11", 1'b0, -1, 6, 1'b1, 0);
        io_en = 1; async_sel = 1; io_ws = 0; tmo = 8'd10;
        run_acc("R11", 1'b1, 3, 5, 1'b0, 0);
        tmo = 8'd0;
    endtask

    task automatic t_busy_start();      // R10
        rom_en = 1; io_en = 1; async_sel = 0; rom_ws = 2; io_ws = 9;
        run_acc("R10", 1'b0, 3, 4, 1'b0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_ready();
        t_ready_ignored();
        t_early_ready();
        t_sync_stretch();
        t_async_stretch();
        t_timeout();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule